// File: doc/BRIEF.md
# Predictive Deadbeat Duty Calculator

This block computes, once per switching period, the duty command for peak current-programmed control of a converter that can run either as a buck stage or as a boost stage. At the start of a period the caller presents the sampled inductor current, the sampled input and output voltages, the current target from the outer loop, and a precomputed inductance-over-period constant, then pulses a start strobe. The block predicts the duty that brings the inductor current onto the target by the end of that same period. This is a deadbeat law, so a current error is removed within one period.

Every operand is a signed 32-bit fixed-point word with 12 integer bits and 20 fractional bits. Both mode formulas are recast over a single common denominator. The block forms one numerator with a single fixed-point product, then makes one sequential division by the sampled voltage. The quotient is limited to the range from zero to the duty ceiling, then scaled by the timer period count into a compare value for a PWM counter. A one-cycle done strobe marks the cycle in which that compare value becomes valid.

Top module: `deadbeat_duty`

## Requirements
- R1: With boost_mode = 1 the duty is (vo − vin + K·(ic − iL)) / vo, which equals (1 − vin/vo) + K/vo·(ic − iL). K is l_over_ts, iL is i_meas, ic is i_ref, vin is v_in and vo is v_out.
- R2: With boost_mode = 0 the duty is (vo + K·(ic − iL)) / vin, which equals vo/vin + K/vin·(ic − iL).
- R3: All operands are signed two's-complement words with 20 fractional bits. The product K·(ic − iL) is formed at 64 bits and shifted right arithmetically by 20, so it rounds toward minus infinity. Sums and differences wrap at 32 bits.
- R4: The quotient magnitude is floor(|num|·2^20 / |den|), and its sign is the exclusive-or of the operand signs. A magnitude above 2^31 − 1 saturates. A zero divisor always gives the largest positive value, 0x7FFFFFFF, whatever the numerator's sign.
- R5: A negative quotient clamps the duty to zero, so compare = 0.
- R6: A quotient above 0.7 (raw 734003) clamps to raw 734003, which gives compare = 10499.
- R7: compare = floor(duty_raw · 15000 / 2^20). For example, a duty of exactly 0.5 gives 7500.
- R8: done is high for exactly one cycle, with the new compare value on the port. It first appears after the 54th rising clock edge, counting the edge that samples start as the first.
- R9: A start pulse while a computation is in progress has no effect: the result and the timing of the running computation are unchanged.
- R10: After reset, done = 0 and compare = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that samples the operands and begins a computation |
| boost_mode | input | 1 | 1 selects the boost law, 0 selects the buck law |
| i_meas | input | 32 | Sampled inductor current, signed 12.20 |
| i_ref | input | 32 | Current target, signed 12.20 |
| v_in | input | 32 | Sampled input voltage, signed 12.20 |
| v_out | input | 32 | Sampled output voltage, signed 12.20 |
| l_over_ts | input | 32 | Inductance divided by switching period, signed 12.20 |
| done | output | 1 | One-cycle strobe: compare is valid |
| compare | output | 14 | Timer compare count for the PWM unit |

## Verification
The bench builds the block with its default parameters: 32-bit words with 20 fractional bits, a period count of 15000 and a ceiling of 700 per mille. Under these parameters the divider takes 52 steps and the compare word is 14 bits, so every case takes a fixed 54 cycles and a sweep of a few hundred operand sets runs quickly. The sweep covers both modes over five input voltages, five output voltages and five current errors. That mix lands results below zero, inside the range and above the ceiling. Directed cases use tiny raw values to show rounding of the product toward minus infinity, zero divisors in each mode, an exact half duty, and a start pulse issued in the middle of a computation.

// File: rtl/dbd_pkg.sv
package dbd_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } dbd_phase_e;

endpackage

// File: rtl/dbd_fxmul.sv
module dbd_fxmul #(
    parameter int W = 32,
    parameter int F = 20
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] p
);

    logic signed [2*W-1:0] full;

    // full-width signed product, then arithmetic shift back to the working format
    assign full = (2*W)'(a) * (2*W)'(b);
    assign p    = W'(full >>> F);

endmodule

// File: rtl/dbd_divider.sv
module dbd_divider #(
    parameter int W = 32,
    parameter int F = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic signed [W-1:0] num,
    input  logic signed [W-1:0] den,
    output logic                done,
    output logic signed [W-1:0] quo
);

    localparam int IT   = W + F;
    localparam int RW   = W + 1;
    localparam int CNTW = $clog2(IT);
    localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic            busy;
        logic            done;
        logic            neg;
        logic            dzero;
        logic [IT-1:0]   dvd;
        logic [RW-1:0]   rem;
        logic [W-1:0]    dmag;
        logic [IT-2:0]   qt;
        logic [CNTW-1:0] cnt;
        logic [W-1:0]    quo;
    } div_state_t;

    div_state_t s_d, s_q;

    logic [W-1:0]  num_mag, den_mag;
    logic [RW:0]   rem_sh;
    logic          qbit;
    logic [IT-1:0] qt_nx;
    logic [W-1:0]  qmag;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        num_mag  = num[W-1] ? (~num + 1'b1) : num;
        den_mag  = den[W-1] ? (~den + 1'b1) : den;
        rem_sh   = {s_q.rem, s_q.dvd[IT-1]};
        qbit     = (rem_sh >= {2'b00, s_q.dmag});
        qt_nx    = {s_q.qt, qbit};
        qmag     = qt_nx[W-1:0];

        if (!s_q.busy && start) begin
            s_d.busy  = 1'b1;
            s_d.neg   = num[W-1] ^ den[W-1];
            s_d.dzero = (den == '0);
            s_d.dvd   = {num_mag, {F{1'b0}}};
            s_d.rem   = '0;
            s_d.dmag  = den_mag;
            s_d.qt    = '0;
            s_d.cnt   = '0;
        end else if (s_q.busy) begin
            // one restoring step per cycle
            s_d.rem = qbit ? RW'(rem_sh - {2'b00, s_q.dmag}) : RW'(rem_sh);
            s_d.dvd = {s_q.dvd[IT-2:0], 1'b0};
            s_d.qt  = qt_nx[IT-2:0];
            s_d.cnt = s_q.cnt + CNTW'(1);
            if (s_q.cnt == CNTW'(IT - 1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                if (s_q.dzero)
                    s_d.quo = MAXP;
                else if (|qt_nx[IT-1:W-1])
                    s_d.quo = s_q.neg ? MINN : MAXP;
                else
                    s_d.quo = s_q.neg ? (~qmag + 1'b1) : qmag;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done = s_q.done;
    assign quo  = s_q.quo;

    // R9
    no_restart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !s_q.busy);

    // R8
    div_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

endmodule

// File: rtl/deadbeat_duty.sv
module deadbeat_duty #(
    parameter int W           = 32,
    parameter int F           = 20,
    parameter int PERIOD      = 15000,
    parameter int DUTY_MAX_PM = 700,
    localparam int CW         = $clog2(PERIOD + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                boost_mode,
    input  logic signed [W-1:0] i_meas,
    input  logic signed [W-1:0] i_ref,
    input  logic signed [W-1:0] v_in,
    input  logic signed [W-1:0] v_out,
    input  logic signed [W-1:0] l_over_ts,
    output logic                done,
    output logic [CW-1:0]       compare
);

    import dbd_pkg::*;

    localparam logic signed [W-1:0] DMAX =
        W'((64'(DUTY_MAX_PM) << F) / 64'd1000);
    localparam logic [CW-1:0] CMP_MAX =
        CW'((64'(DMAX) * 64'(PERIOD)) >> F);

    typedef struct packed {
        dbd_phase_e    ph;
        logic          done;
        logic [CW-1:0] cmp;
    } top_state_t;

    top_state_t s_d, s_q;

    logic signed [W-1:0] err, prod, vterm, num, den, quo;
    logic                div_start, div_done;
    logic [W-1:0]        duty;
    logic [2*W-1:0]      scaled;

    assign err   = i_ref - i_meas;
    assign vterm = boost_mode ? (v_out - v_in) : v_out;
    assign num   = prod + vterm;
    assign den   = boost_mode ? v_out : v_in;

    assign div_start = (s_q.ph == PH_IDLE) && start;

    dbd_fxmul #(.W(W), .F(F)) u_mul (
        .a (l_over_ts),
        .b (err),
        .p (prod)
    );

    dbd_divider #(.W(W), .F(F)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (num),
        .den   (den),
        .done  (div_done),
        .quo   (quo)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (quo[W-1])
            duty = '0;
        else if (quo > DMAX)
            duty = DMAX;
        else
            duty = quo;
        scaled = (2*W)'(duty) * (2*W)'(PERIOD);

        case (s_q.ph)
            PH_IDLE: begin
                if (start) s_d.ph = PH_WAIT;
            end
            PH_WAIT: begin
                if (div_done) begin
                    s_d.cmp  = CW'(scaled >> F);
                    s_d.done = 1'b1;
                    s_d.ph   = PH_IDLE;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done    = s_q.done;
    assign compare = s_q.cmp;

    // R6
    cmp_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> compare <= CMP_MAX);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_follows_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(div_done));

    // R9
    wait_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_WAIT) && !div_done |=> (s_q.ph == PH_WAIT));

endmodule

// File: tb/deadbeat_duty_test.sv
module deadbeat_duty_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        boost_mode = 1'b0;
    logic signed [31:0] i_meas = '0, i_ref = '0, v_in = '0, v_out = '0, l_over_ts = '0;
    logic        done;
    logic [13:0] compare;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    deadbeat_duty uut (
        .clk(clk), .rst_n(rst_n), .start(start), .boost_mode(boost_mode),
        .i_meas(i_meas), .i_ref(i_ref), .v_in(v_in), .v_out(v_out),
        .l_over_ts(l_over_ts), .done(done), .compare(compare)
    );

    always #10 clk = ~clk;

    function automatic int fx(real x);
        return int'(x * 1048576.0);
    endfunction

    // expected compare from the stated arithmetic
    function automatic int model(bit bst, int il, int ic, int vi, int vo, int k);
        int err, prod, num, den, q, duty;
        longint p64, nm, dm, qm;
        bit neg;
        err  = ic - il;
        p64  = longint'(k) * longint'(err);
        prod = int'(p64 >>> 20);
        num  = bst ? (prod + (vo - vi)) : (prod + vo);
        den  = bst ? vo : vi;
        if (den == 0) q = 32'h7FFFFFFF;
        else begin
            neg = (num < 0) ^ (den < 0);
            nm  = (num < 0) ? -longint'(num) : longint'(num);
            dm  = (den < 0) ? -longint'(den) : longint'(den);
            qm  = (nm << 20) / dm;
            if (qm > 64'sd2147483647) q = neg ? 32'h80000000 : 32'h7FFFFFFF;
            else q = neg ? int'(-qm) : int'(qm);
        end
        if (q < 0) duty = 0;
        else if (q > 734003) duty = 734003;
        else duty = q;
        return int'((longint'(duty) * 15000) >>> 20);
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(bit bst, int il, int ic, int vi, int vo, int k);
        boost_mode = bst; i_meas = il; i_ref = ic; v_in = vi; v_out = vo; l_over_ts = k;
    endtask

    // start at a falling edge, wait for done; lat counts rising edges incl. the sampling one
    task automatic run(bit bst, int il, int ic, int vi, int vo, int k,
                       output int got, output int lat, output bit pulse_ok);
        @(negedge clk);
        drive(bst, il, ic, vi, vo, k);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        got = int'(compare);
        @(negedge clk);
        pulse_ok = !done;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int got, lat, exp;
        bit pok;
        int vlist[5];
        int elist[5];
        int k20;
        vlist = '{fx(24.0), fx(48.0), fx(100.0), fx(150.0), fx(300.0)};
        elist = '{fx(-3.0), fx(-0.5), 0, fx(0.25), fx(2.0)};
        k20 = fx(20.0);

        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 done at reset", int'(done), 0);
        check("R10 compare at reset", int'(compare), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8 latency and single-cycle strobe; R7 exact half duty in buck mode
        run(1'b0, fx(5.0), fx(5.0), fx(100.0), fx(50.0), k20, got, lat, pok);
        check("R7 half duty", got, 7500);
        check("R8 latency", lat, 54);
        check("R8 one-cycle done", int'(pok), 1);

        // sweep both modes: R1 boost, R2 buck
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 5; a++)
                for (int b = 0; b < 5; b++)
                    for (int e = 0; e < 5; e++) begin
                        exp = model(m[0], fx(5.0), fx(5.0) + elist[e], vlist[a], vlist[b], k20);
                        run(m[0], fx(5.0), fx(5.0) + elist[e], vlist[a], vlist[b], k20, got, lat, pok);
                        check(m == 1 ? "R1 boost sweep" : "R2 buck sweep", got, exp);
                    end

        // R1 boost in-range value: vin 60, vo 100, no error -> 0.4 -> 5999
        run(1'b1, fx(2.0), fx(2.0), fx(60.0), fx(100.0), k20, got, lat, pok);
        check("R1 boost 0.4", got, 5999);

        // R3 product rounds toward minus infinity: raw vo 2, vin 8, K 3, err -0.5 -> num 0
        run(1'b0, 0, fx(-0.5), 8, 2, 3, got, lat, pok);
        check("R3 floor product", got, 0);
        run(1'b0, 0, fx(0.5), 8, 2, 3, got, lat, pok);
        check("R3 positive product", got, 5625);

        // R4 zero divisor saturates positive
        run(1'b0, fx(1.0), fx(1.0), 0, fx(10.0), k20, got, lat, pok);
        check("R4 buck zero vin", got, 10499);
        run(1'b1, fx(1.0), fx(1.0), fx(50.0), 0, k20, got, lat, pok);
        check("R4 boost zero vo negative num", got, 10499);

        // R5 negative duty clamps to zero
        run(1'b0, fx(10.0), fx(1.0), fx(100.0), fx(20.0), k20, got, lat, pok);
        check("R5 negative clamp", got, 0);

        // R6 ceiling: boost vin 10, vo 100 -> 0.9 clamps to 0.7
        run(1'b1, fx(3.0), fx(3.0), fx(10.0), fx(100.0), k20, got, lat, pok);
        check("R6 ceiling", got, 10499);

        // R9 start during a computation is ignored
        @(negedge clk);
        drive(1'b0, fx(5.0), fx(5.0), fx(100.0), fx(50.0), k20);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        repeat (10) begin @(negedge clk); lat++; end
        drive(1'b1, fx(3.0), fx(3.0), fx(10.0), fx(100.0), k20);
        start = 1'b1;
        @(negedge clk);
        lat++;
        start = 1'b0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check("R9 result unchanged", int'(compare), 7500);
        check("R9 latency unchanged", lat, 54);
        repeat (60) @(negedge clk);
        check("R9 no second done", int'(done), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule